// File: doc/BRIEF.md
# Greedy Pursuit Atom Selector

This block runs the column-selection and residual-update half of an orthogonal-matching-pursuit reconstruction loop. A measurement vector is first written into an internal residual store. After a start pulse the block sweeps every column of the measurement matrix, one entry per cycle, through an external read port. For each column it forms the inner product of that column with the current residual and keeps the column whose correlation has the largest magnitude.

When the sweep ends, the winning column is placed in the support list and excluded from later sweeps. Its index is then offered to an external least-squares engine. The block waits on a valid/ready handshake for the coefficient of that column, and then subtracts coefficient times column from the residual, one row per cycle. After a fixed number of iterations it raises a one-cycle completion pulse, with every selected index packed in selection order.

Top module: `omp_atom_selector`

## Requirements
- R1: While idle, a write with `y_we` high stores `y_data` as the residual of row `y_addr`. Writes and `start` pulses seen while busy have no effect on the run or on the residual.
- R2: Each iteration selects the column j, not yet in the support, that maximises |sum over rows of residual[i]*m[i][j]|. Entries are 16-bit two's complement and the sum is kept in 40 bits.
- R3: When two candidate columns have equal correlation magnitude, the lower column index is selected.
- R4: A column that has been selected is never selected again in the same run, so all indices in the support list are distinct.
- R5: After each sweep `coef_ready` is high and `sel_idx` shows the selected column. Both hold for as long as `coef_valid` stays low, and `coef_ready` falls in the cycle after the handshake.
- R6: On the handshake with coefficient c, every residual row becomes residual[i] - c*m[i][sel], kept modulo 2^16 as a signed value. The next sweep uses the updated residual.
- R7: After exactly K handshakes, `done` is high for one cycle. `support` holds the K indices, the n-th selected one in bits [n*CW +: CW], where CW = log2(COLS).
- R8: Out of reset the block is idle, with `busy`, `done` and `coef_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| y_we | input | 1 | Residual load strobe, honoured when idle |
| y_addr | input | RW | Residual row to load |
| y_data | input | DW | Measurement value to load |
| start | input | 1 | Begin a run, honoured when idle |
| mat_row | output | RW | Matrix row being read |
| mat_col | output | CW | Matrix column being read |
| mat_data | input | DW | Matrix entry at mat_row/mat_col, same cycle |
| coef_ready | output | 1 | Selection made, waiting for its coefficient |
| coef_valid | input | 1 | Coefficient present |
| coef_data | input | DW | Signed coefficient for the selected column |
| sel_idx | output | CW | Column selected in the current iteration |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| support | output | K*CW | Selected indices in selection order |

## Verification
A general matrix with mixed-sign entries is driven with a measurement made from two columns. Exact-cancelling coefficients then show that the residual update feeds the next sweep. A second matrix holds a column that is the negation of another, with the measurement equal to the first. This separates strict from non-strict magnitude comparison (the tie goes to the lower index) and shows masking, because the twin is taken next. An all-zero measurement shows the behaviour when every correlation ties, and confirms the packing order of the support list. A run with a negative correlation, stray residual writes, a second start pulse and a delayed coefficient shows that the comparison uses magnitude, that inputs seen while busy are ignored, and that the block waits on the handshake.

// File: rtl/omp_atom_selector.sv
module omp_atom_selector #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  parameter int K    = 3,
  parameter int DW   = 16,
  parameter int AW   = 40,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int KW  = (K > 1) ? $clog2(K) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            y_we,
  input  logic [RW-1:0]   y_addr,
  input  logic [DW-1:0]   y_data,
  input  logic            start,
  output logic [RW-1:0]   mat_row,
  output logic [CW-1:0]   mat_col,
  input  logic [DW-1:0]   mat_data,
  output logic            coef_ready,
  input  logic            coef_valid,
  input  logic [DW-1:0]   coef_data,
  output logic [CW-1:0]   sel_idx,
  output logic            busy,
  output logic            done,
  output logic [K*CW-1:0] support
);

  typedef enum logic [2:0] {S_IDLE, S_CORR, S_COEF, S_UPD, S_DONE} state_t;
  state_t state;

  logic signed [DW-1:0]   resid [ROWS];
  logic [RW-1:0]          row;
  logic [CW-1:0]          col, best_idx, sel;
  logic [KW-1:0]          iter;
  logic [COLS-1:0]        mask;
  logic signed [AW-1:0]   acc;
  logic [AW-1:0]          best_abs;
  logic                   best_vld;
  logic signed [DW-1:0]   coef;

  wire last_row = (row == RW'(ROWS - 1));
  wire last_col = (col == CW'(COLS - 1));

  wire signed [2*DW-1:0] prod  = resid[row] * $signed(mat_data);
  wire signed [2*DW-1:0] cprod = coef * $signed(mat_data);
  wire signed [AW-1:0]   full  = acc + {{(AW-2*DW){prod[2*DW-1]}}, prod};
  wire [AW-1:0]          fabs  = full[AW-1] ? AW'(-full) : AW'(full);
  wire                   take  = !mask[col] && (!best_vld || fabs > best_abs);
  wire [CW-1:0]          winner = take ? col : best_idx;
  wire signed [DW-1:0]   upd   = resid[row] - cprod[DW-1:0];

  assign mat_row    = row;
  assign mat_col    = (state == S_UPD) ? sel : col;
  assign coef_ready = (state == S_COEF);
  assign sel_idx    = sel;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (state == S_IDLE && y_we) resid[y_addr] <= y_data;
    else if (state == S_UPD)     resid[row]    <= upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; row <= '0; col <= '0; iter <= '0; mask <= '0;
      acc <= '0; best_abs <= '0; best_vld <= 1'b0; best_idx <= '0;
      sel <= '0; coef <= '0; support <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_CORR; row <= '0; col <= '0; iter <= '0;
          mask <= '0; acc <= '0; best_vld <= 1'b0;
        end
        S_CORR: begin
          if (last_row) begin
            acc <= '0;
            row <= '0;
            if (take) begin
              best_abs <= fabs; best_idx <= col; best_vld <= 1'b1;
            end
            if (last_col) begin
              sel <= winner;
              mask[winner] <= 1'b1;
              support[iter*CW +: CW] <= winner;
              state <= S_COEF;
            end else col <= col + 1'b1;
          end else begin
            acc <= full;
            row <= row + 1'b1;
          end
        end
        S_COEF: if (coef_valid) begin
          coef <= coef_data; row <= '0; state <= S_UPD;
        end
        S_UPD: begin
          if (last_row) begin
            row <= '0;
            if (iter == KW'(K - 1)) state <= S_DONE;
            else begin
              iter <= iter + 1'b1; col <= '0; acc <= '0;
              best_vld <= 1'b0; state <= S_CORR;
            end
          end else row <= row + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held longer than one cycle");

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready) |=> !coef_ready) else $error("ready stayed after handshake");

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_ready && !coef_valid) |=> (coef_ready && $stable(sel_idx)))
    else $error("selection not held while waiting");

  assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done) else $error("done at run start");

  always_ff @(posedge clk) begin
    if (rst_n && done)
      for (int a = 0; a < K; a++)
        for (int b = a + 1; b < K; b++)
          assert_support_distinct_R4: assert (support[a*CW +: CW] != support[b*CW +: CW])
            else $error("repeated support index");
  end

endmodule

// File: tb/omp_atom_selector_tb.sv
module omp_atom_selector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8, COLS = 16, K = 3, DW = 16;
  localparam int RW = $clog2(ROWS), CW = $clog2(COLS);

  logic clk = 0, rst_n = 0;
  logic y_we = 0, start = 0, coef_valid = 0;
  logic [RW-1:0] y_addr = '0;
  logic [DW-1:0] y_data = '0, coef_data = '0;
  logic [RW-1:0] mat_row;
  logic [CW-1:0] mat_col, sel_idx;
  logic [DW-1:0] mat_data;
  logic coef_ready, busy, done;
  logic [K*CW-1:0] support;

  int phi [ROWS][COLS];
  int tests = 0, fails = 0, done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mat_data = DW'(phi[mat_row][mat_col]);

  omp_atom_selector #(.ROWS(ROWS), .COLS(COLS), .K(K), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .y_we(y_we), .y_addr(y_addr), .y_data(y_data),
    .start(start), .mat_row(mat_row), .mat_col(mat_col), .mat_data(mat_data),
    .coef_ready(coef_ready), .coef_valid(coef_valid), .coef_data(coef_data),
    .sel_idx(sel_idx), .busy(busy), .done(done), .support(support));

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_y(input int y [ROWS]);
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk); y_we = 1; y_addr = RW'(i); y_data = DW'(y[i]);
    end
    @(negedge clk); y_we = 0;
  endtask

  function automatic int wrap16(input longint v);
    return int'(shortint'(v));
  endfunction

  task automatic run(input int y [ROWS], input int cf [K], input bit disturb,
                     input int delay, output int got [K]);
    int r [ROWS];
    int exp_sel [K];
    bit msk [COLS];
    int d0;
    for (int i = 0; i < ROWS; i++) r[i] = y[i];
    for (int j = 0; j < COLS; j++) msk[j] = 0;
    for (int it = 0; it < K; it++) begin
      longint best; int bi; bit have;
      have = 0; best = 0; bi = 0;
      for (int j = 0; j < COLS; j++) begin
        longint c;
        c = 0;
        for (int i = 0; i < ROWS; i++) c += longint'(r[i]) * phi[i][j];
        if (c < 0) c = -c;
        if (!msk[j] && (!have || c > best)) begin best = c; bi = j; have = 1; end
      end
      exp_sel[it] = bi; msk[bi] = 1;
      for (int i = 0; i < ROWS; i++) r[i] = wrap16(longint'(r[i]) - longint'(cf[it]) * phi[i][bi]);
    end
    load_y(y);
    d0 = done_cnt;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (disturb) begin
      for (int i = 0; i < ROWS; i++) begin
        @(negedge clk); y_we = 1; y_addr = RW'(i); y_data = DW'(1234);
      end
      @(negedge clk); y_we = 0; start = 1;
      @(negedge clk); start = 0;
      chk(busy === 1'b1, "R1 busy through stray inputs", int'(busy), 1);
    end
    for (int it = 0; it < K; it++) begin
      while (coef_ready !== 1'b1) @(negedge clk);
      got[it] = int'(sel_idx);
      chk(int'(sel_idx) == exp_sel[it], "R2 selected column", int'(sel_idx), exp_sel[it]);
      for (int w = 0; w < delay; w++) begin
        @(negedge clk);
        chk(coef_ready === 1'b1 && int'(sel_idx) == exp_sel[it], "R5 hold while waiting",
            int'(sel_idx), exp_sel[it]);
      end
      coef_valid = 1; coef_data = DW'(cf[it]);
      @(negedge clk); coef_valid = 0;
      chk(coef_ready === 1'b0, "R5 ready falls after handshake", int'(coef_ready), 0);
    end
    while (done !== 1'b1) @(negedge clk);
    for (int it = 0; it < K; it++)
      chk(int'(support[it*CW +: CW]) == exp_sel[it], "R7 support order",
          int'(support[it*CW +: CW]), exp_sel[it]);
    @(negedge clk);
    chk(done === 1'b0 && done_cnt == d0 + 1, "R7 single done pulse", done_cnt - d0, 1);
    chk(busy === 1'b0, "R7 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int y [ROWS];
    int cf [K];
    int got [K];
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) phi[i][j] = ((i * 7 + j * 13 + 3) % 11) - 5;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && coef_ready === 0, "R8 reset state",
        int'({busy, done, coef_ready}), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R6: two-column measurement, exact-cancelling coefficients
    for (int i = 0; i < ROWS; i++) y[i] = 3 * phi[i][4] - 2 * phi[i][9];
    cf = '{3, -2, 1};
    run(y, cf, 0, 0, got);

    // R3 R4: column 5 is the negation of column 2
    for (int i = 0; i < ROWS; i++) begin phi[i][5] = -phi[i][2]; y[i] = phi[i][2]; end
    cf = '{0, 0, 0};
    run(y, cf, 0, 1, got);
    chk(got[0] == 2, "R3 tie goes to lower index", got[0], 2);
    chk(got[1] == 5, "R4 masked column skipped", got[1], 5);

    // R7: all-zero residual, all ties
    for (int i = 0; i < ROWS; i++) y[i] = 0;
    run(y, cf, 0, 0, got);
    chk(support == {4'd2, 4'd1, 4'd0}, "R7 packed support", int'(support), 'h210);

    // R1 R5 R6: negative correlation, stray writes and start, delayed coefficient
    for (int i = 0; i < ROWS; i++) y[i] = -4 * phi[i][7];
    cf = '{-4, 2, 0};
    run(y, cf, 1, 4, got);
    chk(got[0] == 7, "R2 magnitude of negative correlation", got[0], 7);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule